// File: doc/BRIEF.md
# Serial Character Transmitter with Break and Idle Generation

This block drives one asynchronous serial line. Software hands it characters of 8 or 9 bits through a single-entry holding buffer. The block wraps each character in a low start bit and a high stop bit and shifts it out least significant bit first. The bit rate comes from an external tick: one bit time is a fixed number of tick pulses, 16 by default. Both the transmitter and its buffer report when they are empty.

Around the data path the block builds the line-control sequences a receiver relies on:
- **Preamble.** Every time the transmitter is switched on, it sends one idle character (a full character time of marks) before anything else.
- **Break.** While a break request is held, the block sends back-to-back break characters, each a whole character time of zeros. When the request is released, the break in flight finishes and is followed by one full mark bit.
- **Disable.** Switching the transmitter off lets the frame in flight end cleanly.
- **Queued idle.** Switching it off and on again during a frame queues one idle character right behind that frame.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset `txd` is 1, `buf_empty` is 1 and `tx_done` is 1. The line stays at 1 whenever no frame is being shifted.
- R2: A data frame is a start bit of 0, then the data bits LSB first, then a stop bit of 1. There are 8 data bits (`wr_data[7:0]`) when `nine_bit`=0, giving 10 bit times, and 9 data bits (`wr_data[8:0]`) when `nine_bit`=1, giving 11 bit times. Characters that are already waiting follow each other with no gap.
- R3: A bit time is TICKS_PER_BIT (16) clock cycles on which `tick` is 1. While a frame is shifting, the line changes only on a cycle with `tick` high. The first bit of a frame started from rest may be short by up to one tick period.
- R4: When `tx_en` rises while nothing is shifting, an idle character starts on that same clock edge. The idle character is all ones and lasts 10 bit times (`nine_bit`=0) or 11 bit times (`nine_bit`=1). A character that is already buffered starts right after it.
- R5: A write (`wr_valid`=1) fills the buffer, and `buf_empty` goes to 0. `buf_empty` returns to 1 on the edge where that character's start bit begins. With the transmitter enabled and the line at rest, the start bit begins on the first edge after the write. `tx_done` is 1 only when no frame is shifting and the buffer is empty.
- R6: While `brk_req` and `tx_en` are both 1, break characters of all zeros are sent back to back, each 10 or 11 bit times long (zeros in the stop position too). A break requested at rest starts on that same edge and takes priority over buffered data.
- R7: After `brk_req` falls, the break in progress completes. Exactly one bit time of 1 then follows before any other frame starts.
- R8: The last zero of a break lasts a full bit time, including when an idle character follows the break.
- R9: If `tx_en` falls during a frame, that frame completes and the line then stays at 1. A buffered character is held back until `tx_en` rises again, and then it follows a fresh preamble.
- R10: If `tx_en` falls and rises again while a frame is shifting, one idle character is sent right after that frame (after the mark bit if the frame was a break), ahead of any buffered data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Bit-rate tick, one clock wide |
| tx_en | input | 1 | Transmitter enable |
| brk_req | input | 1 | Request continuous break characters |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wr_valid | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 9 | Character to send; bit 8 is used only in 9-bit mode |
| txd | output | 1 | Serial line |
| buf_empty | output | 1 | Holding buffer is free |
| tx_done | output | 1 | Buffer empty and no frame shifting |

## Verification
The bench first sweeps every 8-bit value and a spread of 9-bit values back to back. That catches a gap between frames, a wrong bit order and a missing stop bit.

It then places sampling points at the boundaries that are easy to get wrong:
- **Preamble length.** The last preamble cycle is sampled in both data lengths, so a preamble that is missing or one bit short moves the start bit and fails.
- **Break tail.** The last cycle of the final zero must still be 0 and the next cycle must be 1. A half-length stop zero, or a missing trailing mark, would let data or an idle begin early.
- **Disable and re-enable.** Disabling mid-frame must neither truncate the frame nor release the buffered byte. Toggling the enable must push the next byte back by exactly one idle character.
- **Tick rate.** A slowed tick must stretch each data bit to 16 ticks.

// File: rtl/uart_tx_brk.sv
module uart_tx_brk #(
  parameter int TICKS_PER_BIT = 16,
  parameter int SHORT_BITS    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                tx_en,
  input  logic                brk_req,
  input  logic                nine_bit,
  input  logic                wr_valid,
  input  logic [SHORT_BITS:0] wr_data,
  output logic                txd,
  output logic                buf_empty,
  output logic                tx_done
);
  localparam int HW = SHORT_BITS + 1;
  localparam int FW = HW + 2;
  localparam int TW = $clog2(TICKS_PER_BIT);
  localparam int BW = $clog2(FW);
  localparam logic [1:0] K_DATA = 2'd0;
  localparam logic [1:0] K_IDLE = 2'd1;
  localparam logic [1:0] K_BRK  = 2'd2;
  localparam logic [1:0] K_MARK = 2'd3;

  logic          en_q, idle_pend, hold_full, active, nx_go;
  logic [HW-1:0] hold;
  logic [1:0]    kind, nx_kind;
  logic [FW-1:0] shreg, nx_pat;
  logic [TW-1:0] tcnt;
  logic [BW-1:0] bcnt, blast, nx_last;

  wire en_rise   = tx_en & ~en_q;
  wire bit_end   = active & tick & (tcnt == TW'(TICKS_PER_BIT - 1));
  wire frame_end = bit_end & (bcnt == blast);
  wire free      = ~active | frame_end;
  wire launch    = free & nx_go;
  wire [BW-1:0] char_last = nine_bit ? BW'(FW - 1) : BW'(FW - 2);
  wire [HW-1:0] payload   = nine_bit ? hold : {1'b1, hold[HW-2:0]};

  always_comb begin
    nx_go   = 1'b1;
    nx_kind = K_IDLE;
    nx_pat  = '1;
    nx_last = char_last;
    if (active && kind == K_BRK && !(brk_req && tx_en)) begin
      nx_kind = K_MARK;
      nx_last = '0;
    end else if (tx_en && (idle_pend || en_rise)) begin
      nx_kind = K_IDLE;
    end else if (tx_en && brk_req) begin
      nx_kind = K_BRK;
      nx_pat  = '0;
    end else if (tx_en && hold_full) begin
      nx_kind = K_DATA;
      nx_pat  = {1'b1, payload, 1'b0};
    end else begin
      nx_go = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      idle_pend <= 1'b0;
      hold      <= '0;
      hold_full <= 1'b0;
      active    <= 1'b0;
      kind      <= K_IDLE;
      shreg     <= '1;
      blast     <= '0;
      bcnt      <= '0;
      tcnt      <= '0;
    end else begin
      en_q <= tx_en;

      if (!tx_en)                           idle_pend <= 1'b0;
      else if (launch && nx_kind == K_IDLE) idle_pend <= 1'b0;
      else if (en_rise)                     idle_pend <= 1'b1;

      if (wr_valid) begin
        hold      <= wr_data;
        hold_full <= 1'b1;
      end else if (launch && nx_kind == K_DATA) begin
        hold_full <= 1'b0;
      end

      if (launch) begin
        active <= 1'b1;
        kind   <= nx_kind;
        shreg  <= nx_pat;
        blast  <= nx_last;
        bcnt   <= '0;
        tcnt   <= '0;
      end else if (frame_end) begin
        active <= 1'b0;
      end else if (active && tick) begin
        tcnt <= bit_end ? '0 : tcnt + 1'b1;
        if (bit_end) begin
          shreg <= {1'b1, shreg[FW-1:1]};
          bcnt  <= bcnt + 1'b1;
        end
      end
    end
  end

  assign txd       = ~active | shreg[0];
  assign buf_empty = ~hold_full;
  assign tx_done   = ~active & ~hold_full;
endmodule

module uart_tx_brk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       tx_en,
  input logic       brk_req,
  input logic       txd,
  input logic       buf_empty,
  input logic       active,
  input logic [1:0] kind,
  input logic       frame_end
);
  a_r9_no_start_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !active) |=> !active);

  a_r3_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick) |=> $stable(txd));

  a_r6_break_is_low: assert property (@(posedge clk) disable iff (!rst_n)
    (active && kind == 2'd2) |-> !txd);

  a_r7_mark_after_break: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && kind == 2'd2 && !brk_req) |=> (active && txd && kind == 2'd3));

  a_r5_empty_at_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> (active && kind == 2'd0 && !txd));

  a_r4_preamble_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_en) && !active) |=> (active && kind == 2'd1));
endmodule

bind uart_tx_brk uart_tx_brk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en), .brk_req(brk_req),
  .txd(txd), .buf_empty(buf_empty), .active(active), .kind(kind),
  .frame_end(frame_end)
);

// File: tb/sim_uart_tx_brk.sv
module sim_uart_tx_brk;
  logic clk = 0, rst_n = 0, tx_en = 0, brk_req = 0, nine_bit = 0, wr_valid = 0;
  logic [8:0] wr_data = '0;
  logic txd, buf_empty, tx_done;
  int cyc = 0, tdiv = 1, n_chk = 0, n_bad = 0;
  bit finished = 0;
  wire tick = (tdiv <= 1) || (cyc % tdiv == 0);

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_tx_brk u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en), .brk_req(brk_req),
    .nine_bit(nine_bit), .wr_valid(wr_valid), .wr_data(wr_data),
    .txd(txd), .buf_empty(buf_empty), .tx_done(tx_done)
  );

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  task automatic write_at(input int k, input logic [8:0] v);
    wait_cyc(k - 1);
    wr_data  = v;
    wr_valid = 1;
    wait_cyc(k);
    wr_valid = 0;
  endtask

  task automatic check_frame(input int s, input int nb, input int val, input string rq,
                             input bit nxt, input int nval);
    int word = 0;
    for (int b = 0; b < nb + 2; b++) begin
      wait_cyc(s + 16 * b + 8);
      word |= int'(txd) << b;
      if (b == 0) begin
        chk("R5 buffer freed at start bit", int'(buf_empty), 1);
        if (nxt) write_at(s + 10, 9'(nval));
      end
    end
    chk(rq, word, (1 << (nb + 1)) | (val << 1));
  endtask

  function automatic int v9(input int j);
    return (j == 39) ? 'h1FF : (j * 93 + 256) % 512;
  endfunction

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int e, s, p, b, w, run;
    bit flag;
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(10);
    chk("R1 reset txd", int'(txd), 1);
    chk("R1 reset buf_empty", int'(buf_empty), 1);
    chk("R5 reset tx_done", int'(tx_done), 1);

    wait_cyc(19);
    tx_en = 1;
    write_at(30, 9'h000);
    flag = 1;
    for (int k = 0; k < 10; k++) begin
      wait_cyc(28 + 16 * k);
      if (txd !== 1'b1) flag = 0;
    end
    chk("R4 preamble all ones", int'(flag), 1);
    wait_cyc(179);
    chk("R4 preamble last cycle high", int'(txd), 1);
    chk("R5 buffer held during preamble", int'(buf_empty), 0);
    for (int i = 0; i < 256; i++)
      check_frame(180 + 160 * i, 8, i, "R2 8-bit frame", i < 255, i + 1);
    e = 180 + 160 * 256;
    wait_cyc(e - 1);
    chk("R5 tx_done low while shifting", int'(tx_done), 0);
    wait_cyc(e);
    chk("R5 tx_done at end", int'(tx_done), 1);
    chk("R1 line rests high", int'(txd), 1);

    wait_cyc(e + 20);
    nine_bit = 1;
    w = e + 30;
    write_at(w, 9'(v9(0)));
    for (int j = 0; j < 40; j++)
      check_frame(w + 1 + 176 * j, 9, v9(j), "R2 9-bit frame", j < 39, (j < 39) ? v9(j + 1) : 0);
    e = w + 1 + 176 * 40;

    wait_cyc(e + 9);
    tx_en = 0;
    wait_cyc(e + 19);
    tx_en = 1;
    p = e + 20;
    write_at(p + 5, 9'h0A5);
    wait_cyc(p + 175);
    chk("R4 9-bit preamble 11 bits", int'(txd), 1);
    check_frame(p + 176, 9, 'h0A5, "R4 data after 9-bit preamble", 0, 0);
    e = p + 352;

    wait_cyc(e + 2);
    nine_bit = 0;
    b = e + 10;
    wait_cyc(b - 1);
    brk_req = 1;
    wr_data = 9'h096;
    wr_valid = 1;
    wait_cyc(b);
    wr_valid = 0;
    flag = 1;
    for (int k = 0; k < 30; k++) begin
      if (k == 22) begin
        wait_cyc(b + 359);
        brk_req = 0;
      end
      wait_cyc(b + 16 * k + 8);
      if (txd !== 1'b0) flag = 0;
    end
    chk("R6 three full break characters low", int'(flag), 1);
    chk("R6 break holds off buffered data", int'(buf_empty), 0);
    wait_cyc(b + 479);
    chk("R8 last break zero full length", int'(txd), 0);
    wait_cyc(b + 480);
    chk("R7 mark after break", int'(txd), 1);
    wait_cyc(b + 495);
    chk("R7 mark lasts one bit", int'(txd), 1);
    check_frame(b + 496, 8, 'h096, "R7 data after mark", 0, 0);
    e = b + 656;

    wait_cyc(e + 2);
    nine_bit = 1;
    b = e + 20;
    wait_cyc(b - 1);
    brk_req = 1;
    wait_cyc(b + 49);
    brk_req = 0;
    wait_cyc(b + 59);
    tx_en = 0;
    wait_cyc(b + 69);
    tx_en = 1;
    wait_cyc(b + 168);
    chk("R6 9-bit break stop position low", int'(txd), 0);
    wait_cyc(b + 175);
    chk("R8 final zero full before idle", int'(txd), 0);
    wait_cyc(b + 176);
    chk("R7 mark after 9-bit break", int'(txd), 1);
    write_at(b + 200, 9'h155);
    wait_cyc(b + 300);
    chk("R10 queued idle after break", int'(txd), 1);
    check_frame(b + 368, 9, 'h155, "R10 data after queued idle", 0, 0);
    e = b + 544;

    wait_cyc(e + 2);
    nine_bit = 0;
    w = e + 10;
    write_at(w, 9'h03C);
    s = w + 1;
    fork
      begin
        wait_cyc(s + 49);
        tx_en = 0;
        write_at(s + 60, 9'h0C3);
      end
      check_frame(s, 8, 'h03C, "R9 frame completes after disable", 0, 0);
    join
    wait_cyc(s + 168);
    chk("R9 line high after disable", int'(txd), 1);
    wait_cyc(s + 400);
    chk("R9 line still high", int'(txd), 1);
    chk("R9 buffered byte held", int'(buf_empty), 0);
    chk("R5 tx_done low with buffer full", int'(tx_done), 0);
    wait_cyc(s + 499);
    tx_en = 1;
    p = s + 500;
    wait_cyc(p + 159);
    chk("R9 preamble on re-enable", int'(txd), 1);
    check_frame(p + 160, 8, 'h0C3, "R9 held byte after preamble", 0, 0);
    e = p + 320;

    w = e + 10;
    write_at(w, 9'h05A);
    s = w + 1;
    fork
      begin
        write_at(s + 10, 9'h0A5);
        wait_cyc(s + 39);
        tx_en = 0;
        wait_cyc(s + 59);
        tx_en = 1;
      end
      check_frame(s, 8, 'h05A, "R10 frame during toggle", 0, 0);
    join
    wait_cyc(s + 168);
    chk("R10 idle instead of next start", int'(txd), 1);
    wait_cyc(s + 319);
    chk("R10 idle lasts full character", int'(txd), 1);
    check_frame(s + 320, 8, 'h0A5, "R10 data after queued idle", 0, 0);
    e = s + 480;

    wait_cyc(e + 5);
    tdiv = 2;
    write_at(e + 10, 9'h00F);
    while (txd !== 1'b0) @(negedge clk);
    while (txd !== 1'b1) @(negedge clk);
    run = 0;
    while (txd === 1'b1) begin
      run++;
      @(negedge clk);
    end
    chk("R3 four ones at half tick rate", run, 128);
    run = 0;
    while (txd === 1'b0) begin
      run++;
      @(negedge clk);
    end
    chk("R3 four zeros at half tick rate", run, 128);

    finished = 1;
    summary();
    $finish;
  end
endmodule